// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the management register set of a simple 10/100 Ethernet PHY. A management master presents requests on a one-cycle request port. Each request carries a PHY address, a register number, a read or write flag and write data. The block answers only when the PHY address equals the address strapped on `cfg_phy_addr`. Read data comes back one clock after the request, marked by a single-cycle valid pulse. Writes are silent.

The block holds four stored registers: control, two identifier words and the ability advertisement. Three read-only views are computed when they are read:
- a basic status word, which follows the `link_up` input;
- a partner-ability word, which mirrors the advertised abilities;
- a diagnostic word (register 18 by default), which reports the resolved speed and duplex.

The resolved speed and duplex also drive two output pins. Both are computed from the advertisement register alone. Serial bit framing on the management wire and real auto-negotiation are not modelled.

Top module: `mdio_phy_mgmt`

## Requirements
- R1: After reset the registers read as follows: register 0 (control) 0x3100, register 2 0x0300, register 3 0xE400, register 4 (advertisement) 0x01E1.
- R2: Every accepted write leaves control bits 15 and 9 at zero. A write to register 0 stores the written value with mask 0x8200 cleared.
- R3: Writes to registers 2, 3 and 4 store the full 16-bit value, and later reads return it.
- R4: A request whose PHY address differs from `cfg_phy_addr` changes no register. A read of that kind still pulses `rsp_valid`, with `rsp_rdata` equal to 0.
- R5: `speed_100` is 1 when advertisement bit 7 or bit 8 is set. While `link_up` is 1, bit 10 of the diagnostic register carries the same value.
- R6: `full_duplex` is 1 when advertisement bit 8 or bit 6 is set. While `link_up` is 1, bit 11 of the diagnostic register carries the same value.
- R7: Register 5 (partner ability) reads as advertisement AND 0x01E0, so bits 8..5 keep their positions.
- R8: Register 1 (status) reads 0x782D while `link_up` is 1 and 0x7809 while it is 0, so the link bit (2) and the negotiation-done bit (5) clear on link loss. The diagnostic register reads 0 while `link_up` is 0.
- R9: Writes to registers 1 and 5 and to any unimplemented register number are ignored. Unimplemented registers read as 0.
- R10: `rsp_valid` is high exactly in the cycle after each read request, including back-to-back reads. It never rises after a write.
- R11: Status and diagnostic reads use the `link_up` value present at the clock edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_phy_addr | input | 5 | PHY address this responder answers to |
| link_up | input | 1 | Line link indication |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| speed_100 | output | 1 | Resolved 100 Mb/s speed |
| full_duplex | output | 1 | Resolved full duplex |

## Verification
Two things can meet in one cycle: a change on `link_up` and a status or diagnostic read. The bench provokes this by changing `link_up` on the same falling edge that presents the read. It expects the response to reflect the new link value, because that value is present at the accepting clock edge. A second overlap is an advertisement write and the speed/duplex pins. The bench samples the pins one edge after the write and compares them with the bits just written, and then reads the diagnostic register to confirm that its bits agree with the pins.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;

    localparam int REG_W     = 16;
    localparam int REG_IDX_W = 5;

    localparam logic [REG_W-1:0] CTRL_RST_VAL  = 16'h3100;
    localparam logic [REG_W-1:0] IDHI_RST_VAL  = 16'h0300;
    localparam logic [REG_W-1:0] IDLO_RST_VAL  = 16'hE400;
    localparam logic [REG_W-1:0] ADV_RST_VAL   = 16'h01E1;
    localparam logic [REG_W-1:0] CTRL_AUTO_CLR = 16'h8200;
    localparam logic [REG_W-1:0] STAT_FIXED    = 16'h7809;
    localparam logic [REG_W-1:0] STAT_LIVE     = 16'h0024;
    localparam logic [REG_W-1:0] PARTNER_MASK  = 16'h01E0;

    localparam logic [REG_IDX_W-1:0] NUM_CTRL = 5'd0;
    localparam logic [REG_IDX_W-1:0] NUM_STAT = 5'd1;
    localparam logic [REG_IDX_W-1:0] NUM_IDHI = 5'd2;
    localparam logic [REG_IDX_W-1:0] NUM_IDLO = 5'd3;
    localparam logic [REG_IDX_W-1:0] NUM_ADV  = 5'd4;
    localparam logic [REG_IDX_W-1:0] NUM_PART = 5'd5;

    localparam int ADV_BIT_10F  = 6;
    localparam int ADV_BIT_100H = 7;
    localparam int ADV_BIT_100F = 8;
    localparam int DIAG_BIT_SPD = 10;
    localparam int DIAG_BIT_FD  = 11;

    // stored register image
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] id_hi;
        logic [REG_W-1:0] id_lo;
        logic [REG_W-1:0] adv;
    } phy_regs_t;

    // accepted write, already qualified by address match
    typedef struct packed {
        logic             wr;
        logic             sel_ctrl;
        logic             sel_idhi;
        logic             sel_idlo;
        logic             sel_adv;
        logic [REG_W-1:0] wdata;
    } wr_req_t;

    // read request; selects only set on address match
    typedef struct packed {
        logic rd;
        logic hit;
        logic sel_ctrl;
        logic sel_stat;
        logic sel_idhi;
        logic sel_idlo;
        logic sel_adv;
        logic sel_part;
        logic sel_diag;
    } rd_req_t;

    function automatic logic adv_speed100(input logic [REG_W-1:0] adv);
        return adv[ADV_BIT_100H] | adv[ADV_BIT_100F];
    endfunction

    function automatic logic adv_full_dup(input logic [REG_W-1:0] adv);
        return adv[ADV_BIT_100F] | adv[ADV_BIT_10F];
    endfunction

    function automatic logic [REG_W-1:0] status_word(input logic link);
        return STAT_FIXED | (link ? STAT_LIVE : '0);
    endfunction

    function automatic logic [REG_W-1:0] diag_word(input logic link,
                                                   input logic [REG_W-1:0] adv);
        logic [REG_W-1:0] w;
        w = '0;
        if (link) begin
            w[DIAG_BIT_SPD] = adv_speed100(adv);
            w[DIAG_BIT_FD]  = adv_full_dup(adv);
        end
        return w;
    endfunction

endpackage

// File: rtl/mdio_req_decode.sv
module mdio_req_decode
    import mdio_phy_pkg::*;
#(
    parameter int PHY_ADDR_W = 5,
    parameter int DIAG_NUM   = 18,
    parameter bit DIAG_EN    = 1'b1
) (
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [PHY_ADDR_W-1:0] req_phy,
    input  logic [REG_IDX_W-1:0]  req_reg,
    input  logic [REG_W-1:0]      req_wdata,
    input  logic [PHY_ADDR_W-1:0] cfg_phy_addr,
    output wr_req_t               wr_req,
    output rd_req_t               rd_req
);
    localparam logic [REG_IDX_W-1:0] DIAG_IDX = REG_IDX_W'(DIAG_NUM);

    logic hit;
    logic is_diag;

    assign hit = (req_phy == cfg_phy_addr);

    generate
        if (DIAG_EN) begin : g_diag
            assign is_diag = (req_reg == DIAG_IDX);
        end else begin : g_nodiag
            assign is_diag = 1'b0;
        end
    endgenerate

    always_comb begin
        wr_req          = '0;
        wr_req.wr       = req_valid & req_write & hit;
        wr_req.sel_ctrl = hit & (req_reg == NUM_CTRL);
        wr_req.sel_idhi = hit & (req_reg == NUM_IDHI);
        wr_req.sel_idlo = hit & (req_reg == NUM_IDLO);
        wr_req.sel_adv  = hit & (req_reg == NUM_ADV);
        wr_req.wdata    = req_wdata;

        rd_req          = '0;
        rd_req.rd       = req_valid & ~req_write;
        rd_req.hit      = hit;
        rd_req.sel_ctrl = hit & (req_reg == NUM_CTRL);
        rd_req.sel_stat = hit & (req_reg == NUM_STAT);
        rd_req.sel_idhi = hit & (req_reg == NUM_IDHI);
        rd_req.sel_idlo = hit & (req_reg == NUM_IDLO);
        rd_req.sel_adv  = hit & (req_reg == NUM_ADV);
        rd_req.sel_part = hit & (req_reg == NUM_PART);
        rd_req.sel_diag = hit & is_diag;
    end
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
    import mdio_phy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wr_req_t   wr_req,
    output phy_regs_t regs
);
    phy_regs_t regs_q;
    phy_regs_t regs_n;

    always_comb begin
        regs_n = regs_q;
        if (wr_req.wr) begin
            if (wr_req.sel_ctrl) regs_n.ctrl  = wr_req.wdata;
            if (wr_req.sel_idhi) regs_n.id_hi = wr_req.wdata;
            if (wr_req.sel_idlo) regs_n.id_lo = wr_req.wdata;
            if (wr_req.sel_adv)  regs_n.adv   = wr_req.wdata;
            // any accepted write drops the self-clearing control bits
            regs_n.ctrl = regs_n.ctrl & ~CTRL_AUTO_CLR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.ctrl  <= CTRL_RST_VAL;
            regs_q.id_hi <= IDHI_RST_VAL;
            regs_q.id_lo <= IDLO_RST_VAL;
            regs_q.adv   <= ADV_RST_VAL;
        end else begin
            regs_q <= regs_n;
        end
    end

    assign regs = regs_q;

    // R2: control write lands with the self-clearing bits gone
    a_r2_ctrl_autoclr: assert property (@(posedge clk) disable iff (rst)
        (wr_req.wr && wr_req.sel_ctrl) |=> (regs_q.ctrl == ($past(wr_req.wdata) & ~CTRL_AUTO_CLR)));

    // R3: advertisement write stored verbatim
    a_r3_adv_store: assert property (@(posedge clk) disable iff (rst)
        (wr_req.wr && wr_req.sel_adv) |=> (regs_q.adv == $past(wr_req.wdata)));

    // R9: write hitting no stored register leaves the image untouched
    a_r9_nop_write: assert property (@(posedge clk) disable iff (rst)
        (wr_req.wr && !wr_req.sel_ctrl && !wr_req.sel_idhi && !wr_req.sel_idlo && !wr_req.sel_adv
         && ((regs_q.ctrl & CTRL_AUTO_CLR) == '0))
        |=> $stable(regs_q));
endmodule

// File: rtl/mdio_read_path.sv
module mdio_read_path
    import mdio_phy_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rd_req_t          rd_req,
    input  phy_regs_t        regs,
    input  logic             link_up,
    output logic             rsp_valid,
    output logic [REG_W-1:0] rsp_rdata
);
    logic [REG_W-1:0] rdata_n;
    logic             valid_q;
    logic [REG_W-1:0] rdata_q;

    always_comb begin
        rdata_n = '0;
        unique case (1'b1)
            rd_req.sel_ctrl: rdata_n = regs.ctrl;
            rd_req.sel_stat: rdata_n = status_word(link_up);
            rd_req.sel_idhi: rdata_n = regs.id_hi;
            rd_req.sel_idlo: rdata_n = regs.id_lo;
            rd_req.sel_adv:  rdata_n = regs.adv;
            rd_req.sel_part: rdata_n = regs.adv & PARTNER_MASK;
            rd_req.sel_diag: rdata_n = diag_word(link_up, regs.adv);
            default:         rdata_n = '0;
        endcase
        if (!rd_req.hit) rdata_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            valid_q <= rd_req.rd;
            if (rd_req.rd) rdata_q <= rdata_n;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_rdata = rdata_q;

    // R10: exactly one response pulse per read request
    a_r10_rsp_follows_rd: assert property (@(posedge clk) disable iff (rst)
        rd_req.rd |=> rsp_valid);
    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !rd_req.rd |=> !rsp_valid);

    // R4: a read to a foreign address answers zero
    a_r4_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req.rd && !rd_req.hit) |=> (rsp_rdata == '0));

    // R8: link loss hides link and negotiation-done in status
    a_r8_link_down_status: assert property (@(posedge clk) disable iff (rst)
        (rd_req.rd && rd_req.sel_stat && !link_up) |=> (!rsp_rdata[2] && !rsp_rdata[5]));
endmodule

// File: rtl/mdio_phy_mgmt.sv
module mdio_phy_mgmt
    import mdio_phy_pkg::*;
#(
    parameter int PHY_ADDR_W = 5,
    parameter int DIAG_NUM   = 18,
    parameter bit DIAG_EN    = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PHY_ADDR_W-1:0] cfg_phy_addr,
    input  logic                  link_up,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [PHY_ADDR_W-1:0] req_phy,
    input  logic [REG_IDX_W-1:0]  req_reg,
    input  logic [REG_W-1:0]      req_wdata,
    output logic                  rsp_valid,
    output logic [REG_W-1:0]      rsp_rdata,
    output logic                  speed_100,
    output logic                  full_duplex
);
    wr_req_t   wr_req;
    rd_req_t   rd_req;
    phy_regs_t regs;

    mdio_req_decode #(
        .PHY_ADDR_W (PHY_ADDR_W),
        .DIAG_NUM   (DIAG_NUM),
        .DIAG_EN    (DIAG_EN)
    ) u_decode (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_phy      (req_phy),
        .req_reg      (req_reg),
        .req_wdata    (req_wdata),
        .cfg_phy_addr (cfg_phy_addr),
        .wr_req       (wr_req),
        .rd_req       (rd_req)
    );

    mdio_reg_file u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_req),
        .regs   (regs)
    );

    mdio_read_path u_read (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .regs      (regs),
        .link_up   (link_up),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign speed_100   = adv_speed100(regs.adv);
    assign full_duplex = adv_full_dup(regs.adv);

    // R5: speed pin follows a matched advertisement write
    a_r5_speed_after_adv: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_phy == cfg_phy_addr && req_reg == NUM_ADV)
        |=> (speed_100 == ($past(req_wdata[ADV_BIT_100H]) | $past(req_wdata[ADV_BIT_100F]))));

    // R6: duplex pin follows a matched advertisement write
    a_r6_duplex_after_adv: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_phy == cfg_phy_addr && req_reg == NUM_ADV)
        |=> (full_duplex == ($past(req_wdata[ADV_BIT_100F]) | $past(req_wdata[ADV_BIT_10F]))));

    // R4: foreign-address write leaves the resolved pins alone
    a_r4_miss_write_inert: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_phy != cfg_phy_addr) |=> ($stable(speed_100) && $stable(full_duplex)));
endmodule

// File: tb/tb_mdio_phy_mgmt.sv
`timescale 1ns/1ps
module tb_mdio_phy_mgmt;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  cfg_phy_addr;
    logic        link_up;
    logic        req_valid;
    logic        req_write;
    logic [4:0]  req_phy;
    logic [4:0]  req_reg;
    logic [15:0] req_wdata;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        speed_100;
    logic        full_duplex;

    localparam logic [4:0] ME    = 5'd7;
    localparam logic [4:0] OTHER = 5'd12;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mdio_phy_mgmt dut (
        .clk(clk), .rst(rst), .cfg_phy_addr(cfg_phy_addr), .link_up(link_up),
        .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .speed_100(speed_100), .full_duplex(full_duplex)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10 unexpected response: actual %h expected none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd_link(input logic l, input logic [4:0] phy, input logic [4:0] rn,
                           input logic [15:0] exp, input string tag);
        @(negedge clk);
        link_up   = l;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_phy   = phy;
        req_reg   = rn;
        req_wdata = 16'h0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic rd(input logic [4:0] phy, input logic [4:0] rn,
                      input logic [15:0] exp, input string tag);
        rd_link(link_up, phy, rn, exp, tag);
    endtask

    task automatic wr(input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_phy   = phy;
        req_reg   = rn;
        req_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic adv_case(input logic [15:0] adv, input logic spd, input logic fd);
        wr(ME, 5'd4, adv);
        idle();
        check("R5 speed pin", {15'b0, speed_100}, {15'b0, spd});
        check("R6 duplex pin", {15'b0, full_duplex}, {15'b0, fd});
        check("R10 no pulse after write", {15'b0, rsp_valid}, 16'h0);
        rd(ME, 5'd18, {4'b0, fd, spd, 10'b0}, "R5 R6 diag bits");
        rd(ME, 5'd5, adv & 16'h01E0, "R7 partner ability");
        rd(ME, 5'd4, adv, "R3 adv readback");
        idle();
    endtask

    initial begin
        rst = 1'b1; cfg_phy_addr = ME; link_up = 1'b1;
        req_valid = 1'b0; req_write = 1'b0; req_phy = '0; req_reg = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check("R10 reset rsp_valid", {15'b0, rsp_valid}, 16'h0);
        check("R5 reset speed", {15'b0, speed_100}, 16'h1);
        check("R6 reset duplex", {15'b0, full_duplex}, 16'h1);

        // R1: reset values, back-to-back reads also exercise R10
        rd(ME, 5'd0, 16'h3100, "R1 ctrl");
        rd(ME, 5'd2, 16'h0300, "R1 id hi");
        rd(ME, 5'd3, 16'hE400, "R1 id lo");
        rd(ME, 5'd4, 16'h01E1, "R1 adv");
        rd(ME, 5'd1, 16'h782D, "R8 status link up");
        rd(ME, 5'd5, 16'h01E0, "R7 partner reset");
        rd(ME, 5'd18, 16'h0C00, "R5 R6 diag reset");
        idle();

        // R2: control self-clearing bits
        wr(ME, 5'd0, 16'hFFFF);
        idle();
        check("R10 no pulse after ctrl write", {15'b0, rsp_valid}, 16'h0);
        rd(ME, 5'd0, 16'h7DFF, "R2 ctrl all ones");
        wr(ME, 5'd0, 16'h8200);
        rd(ME, 5'd0, 16'h0000, "R2 ctrl only autoclr bits");
        wr(ME, 5'd0, 16'h1234);
        rd(ME, 5'd0, 16'h1034, "R2 ctrl mixed");
        idle();

        // R3: identifier storage
        wr(ME, 5'd2, 16'hA5C3);
        wr(ME, 5'd3, 16'h0F0F);
        rd(ME, 5'd2, 16'hA5C3, "R3 id hi store");
        rd(ME, 5'd3, 16'h0F0F, "R3 id lo store");
        idle();

        // R5 R6 R7: advertisement combinations
        adv_case(16'h0061, 1'b0, 1'b1);
        adv_case(16'h0081, 1'b1, 1'b0);
        adv_case(16'h0021, 1'b0, 1'b0);
        adv_case(16'h0101, 1'b1, 1'b1);
        adv_case(16'hFE1F, 1'b0, 1'b0);

        // R4: foreign address
        wr(OTHER, 5'd4, 16'h01E1);
        idle();
        check("R4 foreign write speed", {15'b0, speed_100}, 16'h0);
        rd(ME, 5'd4, 16'hFE1F, "R4 adv untouched");
        rd(OTHER, 5'd2, 16'h0000, "R4 foreign read zero");
        rd(OTHER, 5'd1, 16'h0000, "R4 foreign status zero");
        idle();

        // R9: ignored writes and unimplemented registers
        wr(ME, 5'd1, 16'h0000);
        wr(ME, 5'd5, 16'hFFFF);
        wr(ME, 5'd9, 16'hFFFF);
        rd(ME, 5'd1, 16'h782D, "R9 status write ignored");
        rd(ME, 5'd5, 16'h0000, "R9 partner write ignored");
        rd(ME, 5'd9, 16'h0000, "R9 unimplemented reads zero");
        rd(ME, 5'd31, 16'h0000, "R9 reg 31 reads zero");
        rd(ME, 5'd4, 16'hFE1F, "R9 adv untouched");
        idle();

        // R8 R11: link change in the same cycle as the read
        wr(ME, 5'd4, 16'h0101);
        rd_link(1'b0, ME, 5'd1, 16'h7809, "R11 R8 status link drop same cycle");
        rd(ME, 5'd18, 16'h0000, "R8 diag zero link down");
        rd_link(1'b1, ME, 5'd1, 16'h782D, "R11 status link rise same cycle");
        rd_link(1'b0, ME, 5'd18, 16'h0000, "R11 diag link drop same cycle");
        rd_link(1'b1, ME, 5'd18, 16'h0C00, "R11 diag link rise same cycle");
        idle();
        check("R8 pins independent of link", {14'b0, full_duplex, speed_100}, 16'h0003);

        repeat (3) idle();
        check("R10 all responses seen", 16'(exp_q.size()), 16'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule